// File: doc/BRIEF.md
# Cascadable Two-Bit ALU Slice Array

This block is a two-bit data-processing slice and a parameterised wrapper that chains several slices into a wider datapath. Each slice holds twelve two-bit registers: ten scratch registers, a temporary register and an accumulator. It also holds a memory address register, two operand selectors and an ALU. A single 7-bit function code goes to every slice in parallel. Carries ripple from the lowest slice to the highest. The right-shift path runs from the highest slice to the lowest.

A mask bus is ANDed into the second ALU operand on every operation. For that reason the same function code means different things when the mask is all-zeros and when it is all-ones. For example, one code increments a register with a zero mask and adds the accumulator with a full mask. In logic operations the carry output acts as a non-zero flag.

The function code has two fields. The upper three bits pick one of eight function groups. The lower four bits pick a register.

Top module: `bit_slice_array`

## Requirements
- R1: When the active-low reset is asserted, all registers and the address register are cleared, so `aBus` and `dBus` read zero.
- R2: Group 0 (code bits 6..4 = 0) writes `Rsel + (AC & K) + carryIn` to the selected register and to the accumulator. `carryOut` is the carry of that sum.
- R3: Group 1 writes `M + (AC & K) + carryIn` to the selected register. `carryOut` is the arithmetic carry.
- R4: Group 3 loads the address register with `M | K` and writes `M + K + carryIn` to the selected register. With K all-ones, this subtracts one.
- R5: Group 4 writes `(AC & K) + all-ones + carryIn` to the selected register. `carryOut` is the arithmetic carry.
- R6: Group 5 writes `Rsel & (AC & K)`, group 6 writes `Rsel | (AC & K)`, and group 7 writes `~(M ^ (AC & K))` to the selected register.
- R7: In groups 5, 6 and 7, `carryOut` equals `carryIn` ORed with the OR of all result bits.
- R8: Group 2 shifts the selected register right by one. `leftIn` enters the top bit, the bottom bit appears on `rightOut`, and `carryOut` equals `carryIn`. Outside group 2, `rightOut` is 0.
- R9: The register field (code bits 3..0) selects register 0..9 by values 0..9, T by 10 and AC by 11. Values 12..15 select AC as the destination and use the I bus in place of the register or M operand. The exceptions are group 2, which shifts AC, and group 4, which keeps its all-ones operand.
- R10: With SLICES slices the datapath is 2*SLICES bits wide. Carries ripple across every slice, so an add can carry from the lowest bit out of the top slice.
- R11: `aBus` shows the address register and `dBus` shows the accumulator. The address register changes only in group 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| funcCode | input | 7 | Function group (6..4) and register field (3..0) |
| mBus | input | 2*SLICES | M operand bus |
| iBus | input | 2*SLICES | I operand bus |
| kBus | input | 2*SLICES | Mask bus ANDed into the second operand |
| carryIn | input | 1 | Carry into the lowest slice |
| leftIn | input | 1 | Shift input into the top bit |
| aBus | output | 2*SLICES | Address register value |
| dBus | output | 2*SLICES | Accumulator value |
| carryOut | output | 1 | Carry or non-zero flag from the top slice |
| rightOut | output | 1 | Bit shifted out of the lowest slice |

## Verification
The bench targets the places where the mask changes the meaning of a code:
- A design that ignored the mask, or applied it to the wrong operand, would give the same result for all-zeros and all-ones masks.
- A design that treated the all-ones operand as one instead of minus one would give wrong decrement results and wrong carries.

It checks that a carry ripples through all four slices, and that a zero logic result with a carry in of 1 still raises `carryOut`. A broken chain would drop the carry, and a missing OR term would clear the flag. Shifts are checked for the fill bit entering the top and the exit bit leaving on `rightOut`. A reversed shift chain would corrupt both. The bench also checks that register codes 12 to 15 steer the I bus into the accumulator rather than writing a scratch register.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int SLICE_W  = 2;
  localparam int NUM_REGS = 12;
  localparam int REG_AW   = 4;
  localparam int T_IDX    = 10;
  localparam int AC_IDX   = 11;
  localparam int FIRST_IN = 12;

  typedef enum logic [2:0] {
    GRP_ADD_REG  = 3'd0,
    GRP_ADD_MEM  = 3'd1,
    GRP_SHR      = 3'd2,
    GRP_LOAD_MAR = 3'd3,
    GRP_DEC      = 3'd4,
    GRP_AND      = 3'd5,
    GRP_OR       = 3'd6,
    GRP_XNOR     = 3'd7
  } grp_e;

  typedef enum logic [1:0] {
    A_REG  = 2'd0,
    A_MEM  = 2'd1,
    A_IN   = 2'd2,
    A_ONES = 2'd3
  } asrc_e;

  typedef enum logic {
    B_AC   = 1'b0,
    B_ONES = 1'b1
  } bsrc_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XNOR = 2'd3
  } op_e;

  typedef struct packed {
    asrc_e             aSrc;
    bsrc_e             bSrc;
    op_e               aluOp;
    logic              shiftRight;
    logic              arith;
    logic [REG_AW-1:0] destIdx;
    logic              wrDest;
    logic              wrAcToo;
    logic              wrMar;
  } strobe_t;

endpackage

// File: rtl/slice_decode.sv
module slice_decode
  import alu_slice_pkg::*;
(
  input  logic [6:0] funcCode,
  output strobe_t    ctl
);

  grp_e              grp;
  logic [REG_AW-1:0] regField;
  logic              useIn;

  assign grp      = grp_e'(funcCode[6:4]);
  assign regField = funcCode[3:0];
  assign useIn    = (regField >= REG_AW'(FIRST_IN));

  always_comb begin
    ctl.aSrc       = useIn ? A_IN : A_REG;
    ctl.bSrc       = B_AC;
    ctl.aluOp      = OP_ADD;
    ctl.shiftRight = 1'b0;
    ctl.arith      = 1'b1;
    ctl.destIdx    = useIn ? REG_AW'(AC_IDX) : regField;
    ctl.wrDest     = 1'b1;
    ctl.wrAcToo    = 1'b0;
    ctl.wrMar      = 1'b0;
    unique case (grp)
      GRP_ADD_REG: ctl.wrAcToo = 1'b1;
      GRP_ADD_MEM: ctl.aSrc = useIn ? A_IN : A_MEM;
      GRP_SHR: begin
        ctl.aSrc       = A_REG;
        ctl.shiftRight = 1'b1;
        ctl.arith      = 1'b0;
      end
      GRP_LOAD_MAR: begin
        ctl.aSrc  = useIn ? A_IN : A_MEM;
        ctl.bSrc  = B_ONES;
        ctl.wrMar = 1'b1;
      end
      GRP_DEC: ctl.aSrc = A_ONES;
      GRP_AND: begin
        ctl.aluOp = OP_AND;
        ctl.arith = 1'b0;
      end
      GRP_OR: begin
        ctl.aluOp = OP_OR;
        ctl.arith = 1'b0;
      end
      GRP_XNOR: begin
        ctl.aSrc  = useIn ? A_IN : A_MEM;
        ctl.aluOp = OP_XNOR;
        ctl.arith = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import alu_slice_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      ctl,
  input  logic [W-1:0] mIn,
  input  logic [W-1:0] iIn,
  input  logic [W-1:0] kIn,
  input  logic         ci,
  input  logic         li,
  output logic         co,
  output logic         ro,
  output logic [W-1:0] marOut,
  output logic [W-1:0] acOut
);

  logic [W-1:0] regFile [NUM_REGS];
  logic [W-1:0] marQ;
  logic [W-1:0] rdVal;
  logic [W-1:0] acVal;
  logic [W-1:0] aOp;
  logic [W-1:0] bPre;
  logic [W-1:0] bOp;
  logic [W:0]   sum;
  logic [W-1:0] logicRes;
  logic [W-1:0] res;

  assign rdVal = regFile[ctl.destIdx];
  assign acVal = regFile[AC_IDX];

  always_comb begin
    unique case (ctl.aSrc)
      A_REG:   aOp = rdVal;
      A_MEM:   aOp = mIn;
      A_IN:    aOp = iIn;
      default: aOp = '1;
    endcase
  end

  assign bPre = (ctl.bSrc == B_AC) ? acVal : '1;
  assign bOp  = bPre & kIn;
  assign sum  = {1'b0, aOp} + {1'b0, bOp} + {{W{1'b0}}, ci};

  always_comb begin
    unique case (ctl.aluOp)
      OP_AND:  logicRes = aOp & bOp;
      OP_OR:   logicRes = aOp | bOp;
      OP_XNOR: logicRes = ~(aOp ^ bOp);
      default: logicRes = sum[W-1:0];
    endcase
  end

  always_comb begin
    if (ctl.shiftRight) begin
      res = {li, rdVal[W-1:1]};
      co  = ci;
      ro  = rdVal[0];
    end else if (ctl.arith) begin
      res = sum[W-1:0];
      co  = sum[W];
      ro  = 1'b0;
    end else begin
      res = logicRes;
      co  = ci | (|logicRes);
      ro  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
      marQ <= '0;
    end else begin
      if (ctl.wrDest)  regFile[ctl.destIdx] <= res;
      if (ctl.wrAcToo) regFile[AC_IDX]      <= res;
      if (ctl.wrMar)   marQ                 <= aOp | kIn;
    end
  end

  assign marOut = marQ;
  assign acOut  = acVal;

endmodule

// File: rtl/bit_slice_array.sv
module bit_slice_array
  import alu_slice_pkg::*;
#(
  parameter int SLICES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [6:0]                  funcCode,
  input  logic [SLICES*SLICE_W-1:0]   mBus,
  input  logic [SLICES*SLICE_W-1:0]   iBus,
  input  logic [SLICES*SLICE_W-1:0]   kBus,
  input  logic                        carryIn,
  input  logic                        leftIn,
  output logic [SLICES*SLICE_W-1:0]   aBus,
  output logic [SLICES*SLICE_W-1:0]   dBus,
  output logic                        carryOut,
  output logic                        rightOut
);

  strobe_t          ctl;
  logic [SLICES:0]  carryChain;
  logic [SLICES:0]  shiftChain;

  slice_decode u_decode (
    .funcCode (funcCode),
    .ctl      (ctl)
  );

  assign carryChain[0]      = carryIn;
  assign shiftChain[SLICES] = leftIn;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    slice_datapath #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl),
      .mIn    (mBus[s*SLICE_W +: SLICE_W]),
      .iIn    (iBus[s*SLICE_W +: SLICE_W]),
      .kIn    (kBus[s*SLICE_W +: SLICE_W]),
      .ci     (carryChain[s]),
      .li     (shiftChain[s+1]),
      .co     (carryChain[s+1]),
      .ro     (shiftChain[s]),
      .marOut (aBus[s*SLICE_W +: SLICE_W]),
      .acOut  (dBus[s*SLICE_W +: SLICE_W])
    );
  end

  assign carryOut = carryChain[SLICES];
  assign rightOut = shiftChain[0];

endmodule

// File: rtl/bit_slice_array_checker.sv
module bit_slice_array_checker #(
  parameter int SLICES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [6:0]            funcCode,
  input logic [SLICES*2-1:0]   mBus,
  input logic [SLICES*2-1:0]   iBus,
  input logic [SLICES*2-1:0]   kBus,
  input logic                  carryIn,
  input logic                  leftIn,
  input logic [SLICES*2-1:0]   aBus,
  input logic [SLICES*2-1:0]   dBus,
  input logic                  carryOut,
  input logic                  rightOut
);

  localparam int W = SLICES * 2;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (aBus == '0 && dBus == '0)); // R1

  AST_MAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    funcCode[6:4] == 3'd3 |=>
      aBus == ((($past(funcCode[3:0]) >= 4'd12) ? $past(iBus) : $past(mBus)) | $past(kBus))); // R4

  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    funcCode[6:4] != 3'd3 |=> $stable(aBus)); // R11

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (funcCode[6] && funcCode[5:4] != 2'b00 && carryIn) |-> carryOut); // R7

  AST_SHIFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    funcCode[6:4] != 3'd2 |-> !rightOut); // R8

  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    funcCode[6:4] == 3'd2 |-> carryOut == carryIn); // R8

  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (funcCode[6:4] == 3'd2 && funcCode[3:0] >= 4'd12) |=> dBus[W-1] == $past(leftIn)); // R8

endmodule

bind bit_slice_array bit_slice_array_checker #(.SLICES(SLICES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .funcCode (funcCode),
  .mBus     (mBus),
  .iBus     (iBus),
  .kBus     (kBus),
  .carryIn  (carryIn),
  .leftIn   (leftIn),
  .aBus     (aBus),
  .dBus     (dBus),
  .carryOut (carryOut),
  .rightOut (rightOut)
);

// File: tb/sim_bit_slice_array.sv
module sim_bit_slice_array;

  localparam int SLICES = 4;
  localparam int W      = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [6:0]   funcCode = '0;
  logic [W-1:0] mBus = '0, iBus = '0, kBus = '0;
  logic         carryIn = 1'b0, leftIn = 1'b0;
  logic [W-1:0] aBus, dBus;
  logic         carryOut, rightOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [W-1:0] mReg [12];
  logic [W-1:0] mMar;

  always #4 clk = ~clk;

  bit_slice_array #(.SLICES(SLICES)) u0 (
    .clk(clk), .rst_n(rst_n), .funcCode(funcCode), .mBus(mBus), .iBus(iBus),
    .kBus(kBus), .carryIn(carryIn), .leftIn(leftIn), .aBus(aBus), .dBus(dBus),
    .carryOut(carryOut), .rightOut(rightOut)
  );

  // {code, M, K, carry in, expected D, expected carry out}, from a cleared state
  localparam logic [32:0] VEC [0:7] = '{
    {7'h1B, 8'h5A, 8'h00, 1'b1, 8'h5B, 1'b0},  // R3 zero mask
    {7'h1B, 8'hA7, 8'hFF, 1'b0, 8'h02, 1'b1},  // R3 full mask, carry
    {7'h7B, 8'h0F, 8'h00, 1'b0, 8'hF0, 1'b1},  // R6 complement M
    {7'h7B, 8'hF0, 8'hFF, 1'b0, 8'hFF, 1'b1},  // R6 M xnor AC
    {7'h5B, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0},  // R7 zero result, flag low
    {7'h4B, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0},  // R5 carry in minus one
    {7'h4B, 8'h00, 8'hFF, 1'b1, 8'hFF, 1'b1},  // R5 AC minus one plus carry
    {7'h6B, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1}   // R7 non-zero flag
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] g, input logic useIn);
    if (useIn && g != 3'd2 && g != 3'd4) return "R9";
    case (g)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R8";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic modelReset();
    for (int r = 0; r < 12; r++) mReg[r] = '0;
    mMar = '0;
  endtask

  // Called just after a falling edge; returns at the next falling edge.
  task automatic applyOp(input logic [6:0] fc, input logic [W-1:0] m, input logic [W-1:0] i,
                         input logic [W-1:0] k, input logic ci, input logic li,
                         input string tagOverride, output logic coSeen);
    logic [2:0]   g;
    logic         useIn;
    int           dst;
    logic [W-1:0] src, ac, a, b, res;
    logic [W:0]   sum;
    logic         co, ro;
    string        tag;
    g = fc[6:4];
    useIn = (fc[3:0] >= 4'd12);
    dst = useIn ? 11 : int'(fc[3:0]);
    src = mReg[dst];
    ac = mReg[11];
    ro = 1'b0;
    a = '0; b = '0; sum = '0;
    case (g)
      3'd0: begin a = useIn ? i : src; b = ac & k; end
      3'd1: begin a = useIn ? i : m;   b = ac & k; end
      3'd3: begin a = useIn ? i : m;   b = k; end
      3'd4: begin a = '1;              b = ac & k; end
      3'd5, 3'd6: begin a = useIn ? i : src; b = ac & k; end
      default: begin a = useIn ? i : m; b = ac & k; end
    endcase
    sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    case (g)
      3'd2: begin res = {li, src[W-1:1]}; ro = src[0]; co = ci; end
      3'd5: begin res = a & b;     co = ci | (|res); end
      3'd6: begin res = a | b;     co = ci | (|res); end
      3'd7: begin res = ~(a ^ b);  co = ci | (|res); end
      default: begin res = sum[W-1:0]; co = sum[W]; end
    endcase
    tag = (tagOverride != "") ? tagOverride : tagOf(g, useIn);
    funcCode = fc; mBus = m; iBus = i; kBus = k; carryIn = ci; leftIn = li;
    #1;
    coSeen = carryOut;
    chk((g >= 3'd5 && tagOverride == "") ? "R7" : tag, {7'd0, carryOut}, {7'd0, co});
    chk("R8", {7'd0, rightOut}, {7'd0, ro});
    @(posedge clk);
    mReg[dst] = res;
    if (g == 3'd0) mReg[11] = res;
    if (g == 3'd3) mMar = a | k;
    @(negedge clk);
    chk(tag, dBus, mReg[11]);
    chk((g == 3'd3) ? "R4" : "R11", aBus, mMar);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic co;
    modelReset();
    repeat (2) @(negedge clk);
    // R1: cleared state while reset is held
    chk("R1", aBus, 8'h00);
    chk("R1", dBus, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      applyOp(VEC[v][32:26], VEC[v][25:18], 8'h00, VEC[v][17:10], VEC[v][9], 1'b0, "", co);
      chk(tagOf(VEC[v][32:30], 1'b0), dBus, VEC[v][8:1]);
      chk("R7", {7'd0, co}, {7'd0, VEC[v][0]});
    end

    // R10: carry ripples through every slice (FF + 01 -> 00 with carry out)
    applyOp(7'h1B, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, "R10", co);
    applyOp(7'h1B, 8'h01, 8'h00, 8'hFF, 1'b0, 1'b0, "R10", co);
    chk("R10", dBus, 8'h00);
    chk("R10", {7'd0, co}, 8'h01);

    // R8: shift a scratch register and the accumulator through the chain
    applyOp(7'h13, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0, "", co);
    applyOp(7'h23, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R8", co);
    applyOp(7'h03, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R8", co);
    chk("R8", dBus, 8'hC0);
    applyOp(7'h2C, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R8", co);
    chk("R8", dBus, 8'h60);

    // R9: I bus steered into AC
    applyOp(7'h0F, 8'h00, 8'h33, 8'hFF, 1'b0, 1'b0, "R9", co);
    chk("R9", dBus, 8'h93);

    // R4: address register load with both mask extremes
    applyOp(7'h35, 8'h12, 8'h00, 8'h00, 1'b1, 1'b0, "R4", co);
    chk("R4", aBus, 8'h12);
    applyOp(7'h35, 8'h12, 8'h00, 8'hFF, 1'b0, 1'b0, "R4", co);
    chk("R4", aBus, 8'hFF);

    // R7: zero logic result with carry in still reports carry out
    applyOp(7'h50, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R7", co);
    chk("R7", {7'd0, co}, 8'h01);

    // Every group, both mask extremes, random operands (R2..R9, R10 via width)
    for (int g = 0; g < 8; g++) begin
      for (int kk = 0; kk < 2; kk++) begin
        for (int rep = 0; rep < 6; rep++) begin
          applyOp({g[2:0], 4'($urandom_range(15))}, 8'($urandom), 8'($urandom),
                  kk ? 8'hFF : 8'h00, 1'($urandom), 1'($urandom), "", co);
        end
      end
    end

    // Read back every scratch register and T through AC (R2)
    for (int r = 0; r < 11; r++)
      applyOp({3'd0, 4'(r)}, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2", co);

    // R1: reset in mid-run clears the state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", aBus, 8'h00);
    chk("R1", dBus, 8'h00);
    modelReset();
    rst_n = 1'b1;
    @(negedge clk);
    applyOp(7'h04, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R1", co);
    chk("R1", dBus, 8'h00);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule